// File: doc/BRIEF.md
# I2C Byte-Addressable Memory Target

This block is an I2C target in front of a 2,048-byte on-chip memory. The SCL and SDA lines are sampled by the system clock, which runs much faster than SCL. A synchroniser finds SCL edges and the start and stop conditions. The block pulls SDA low through an output-enable, and its data output is held low at all times, so the pad stays open-drain.

A transfer begins with a control byte. The top four bits of the control byte carry the device type. The next three bits are the upper part of the memory address, and the last bit gives the direction. In a write, the byte after the control byte is the lower eight bits of the address, and every byte after that is stored. Each stored byte is committed on its acknowledge clock, so the block has no busy period. In a read, data comes out from the address held in the buffer. A random read is made of a write that carries only the address, then a repeated start with a read control byte. A write-protect input blocks stores and leaves reads working. Pins that can float should tie it low through a pull-down.

Top module: `i2c_mem_target`

## Requirements
- R1: A control byte is acknowledged only when bits 7:4 equal 1010. On any other value the block gives no ACK on that byte, and it stays silent until the next start condition.
- R2: For a write, control bit 0 = 0. Bits 3:1 of the control byte set address bits 10:8. The second byte sets address bits 7:0. The block ACKs both bytes, and a third byte is stored at that address.
- R3: In a write, each further byte goes to the next address. The address wraps from 0x7FF to 0x000.
- R4: A random read returns the stored byte at the address given in the dummy write. The read control byte has bit 0 = 1 and carries the same upper bits.
- R5: A current-address read takes address bits 10:8 from its own control byte. It takes bits 7:0 from the address buffer, which points one past the last byte transferred.
- R6: While the controller ACKs, a read goes on with the following address and wraps the same way as a write. After a NACK the block stops driving SDA until a new start condition.
- R7: While write-protect is high, received data bytes are still ACKed, but the memory is left unchanged. Reads work the same at either level.
- R8: A stop condition in the middle of a byte ends the transfer. The partial byte is not stored, and SDA is released.
- R9: After reset, and whenever the block is idle, SDA is not driven. The data output is constant 0. The output-enable only turns on while SCL is low.
- R10: A start condition at any bit position restarts the protocol at a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| wp_i | input | 1 | Write protect, 1 = block stores |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| sda_o | output | 1 | SDA output value, constant 0 |

## Verification
The assertions assume that SCL and SDA hold each level for several system clocks. They also assume that SDA changes only while SCL is low, except at start and stop, and that write-protect does not change during an acknowledge clock. The bench model spends four system clocks on each quarter bit. It changes SDA in the middle of the SCL low phase and samples in the middle of the high phase. It resolves the bus as a wired-AND of the controller and the target, so the block sees its own drive on SDA.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int UPPER_W = 3;
  localparam int LOWER_W = 8;
  localparam int ADDR_W  = UPPER_W + LOWER_W;
  localparam int BYTE_W  = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } xfer_state_e;

  // next buffer address; wraps by width from top to zero
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic type_match(input logic [BYTE_W-1:0] c);
    return c[BYTE_W-1 -: 4] == DEV_TYPE;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wp,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              mem_we,
  output logic              sda_oe
);
  xfer_state_e       state;
  logic [3:0]        bitcnt;   // 0..7 data bits, 8 = ack clock due, 9 = ack clock high
  logic [BYTE_W-1:0] sreg;
  logic [ADDR_W-1:0] addr;
  logic              rw;

  logic bit_phase, ack_due, ack_done, tx_shift;
  assign bit_phase = bitcnt < 4'd8;
  assign ack_due   = bitcnt == 4'd8;
  assign ack_done  = bitcnt == 4'd9;
  assign tx_shift  = (state == ST_RDATA) && (bitcnt != 4'd0) && bit_phase;
  assign rd_addr   = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sreg    <= '0;
      addr    <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      mem_we  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_evt) begin
        state  <= ST_CTRL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_phase) begin
            bitcnt <= bitcnt + 4'd1;
            if (state != ST_RDATA) sreg <= {sreg[BYTE_W-2:0], sda_s};
          end else if (ack_due) begin
            bitcnt <= 4'd9;
            case (state)
              ST_CTRL: begin
                addr[ADDR_W-1 -: UPPER_W] <= sreg[UPPER_W:1];
                rw <= sreg[0];
              end
              ST_ADDR:  addr[LOWER_W-1:0] <= sreg;
              ST_WDATA: begin
                mem_we  <= !wp;
                wr_addr <= addr;
                wr_data <= sreg;
                addr    <= addr_next(addr);
              end
              ST_RDATA: if (sda_s) state <= ST_IDLE;   // controller NACK
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          if (tx_shift) begin
            sreg   <= {sreg[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sreg[BYTE_W-2];
          end else if (ack_due) begin
            if (state == ST_RDATA) begin
              sda_oe <= 1'b0;
              addr   <= addr_next(addr);
            end else if (state == ST_CTRL && !type_match(sreg)) begin
              state <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
            end
          end else if (ack_done) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              ST_CTRL: begin
                if (rw) begin
                  state  <= ST_RDATA;
                  sreg   <= rd_data;
                  sda_oe <= ~rd_data[BYTE_W-1];
                end else begin
                  state <= ST_ADDR;
                end
              end
              ST_ADDR: state <= ST_WDATA;
              ST_RDATA: begin
                sreg   <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_OE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (state == ST_IDLE && !sda_oe)); // R8
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_CTRL && bitcnt == 4'd0 && !sda_oe)); // R10
  AST_COMMIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> addr == addr_next(wr_addr)); // R3
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R6
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic sda_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic mem_we;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mem_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .wp(wp_i), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_we(mem_we), .sda_oe(sda_oe_o)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign sda_o = 1'b0;

  AST_NO_STORE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!wp_i)); // R7
endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_o;
  wire  sda_bus = sda_m & ~sda_oe;
  int   errors = 0, checks = 0;

  always #10 clk = ~clk;

  i2c_mem_target u_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe_o(sda_oe), .sda_o(sda_o)
  );

  function automatic logic [7:0] pat(input logic [10:0] a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] ctrl(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    w(4); sda_m = b; w(4); scl_m = 1'b1; w(8); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    w(4); sda_m = 1'b1; w(4); scl_m = 1'b1; w(4); b = sda_bus; w(4); scl_m = 1'b0;
  endtask

  task automatic do_start;
    w(4); sda_m = 1'b1; w(4); scl_m = 1'b1; w(8); sda_m = 1'b0; w(8); scl_m = 1'b0;
  endtask

  task automatic do_stop;
    w(4); sda_m = 1'b0; w(4); scl_m = 1'b1; w(8); sda_m = 1'b1; w(8);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic more, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_in(r);
      d[i] = r;
    end
    bit_out(~more);
  endtask

  // write n pattern bytes starting at a
  task automatic write_pat(input logic [10:0] a, input int n);
    logic ack;
    do_start;
    wbyte(ctrl(a, 1'b0), ack); chk(ack, "R1", ack, 1);
    wbyte(a[7:0], ack);        chk(ack, "R2", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(pat(11'(a + i)), ack);
      if (!ack) chk(ack, "R3", ack, 1);
    end
    do_stop;
  endtask

  task automatic write_one(input logic [10:0] a, input logic [7:0] v, input string req);
    logic ack;
    do_start;
    wbyte(ctrl(a, 1'b0), ack); chk(ack, req, ack, 1);
    wbyte(a[7:0], ack);        chk(ack, req, ack, 1);
    wbyte(v, ack);             chk(ack, req, ack, 1);
    do_stop;
  endtask

  // random read of n bytes compared with the pattern
  task automatic read_pat(input logic [10:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    do_start;
    wbyte(ctrl(a, 1'b0), ack); chk(ack, "R4", ack, 1);
    wbyte(a[7:0], ack);
    do_start;
    wbyte(ctrl(a, 1'b1), ack); chk(ack, "R4", ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      if (d != pat(11'(a + i)) || i == n - 1) chk(d == pat(11'(a + i)), req, d, pat(11'(a + i)));
    end
    w(4);
    chk(!sda_oe, "R6", sda_oe, 0);
    do_stop;
  endtask

  task automatic read_one(input logic [10:0] a, output logic [7:0] d);
    logic ack;
    do_start;
    wbyte(ctrl(a, 1'b0), ack);
    wbyte(a[7:0], ack);
    do_start;
    wbyte(ctrl(a, 1'b1), ack);
    rbyte(1'b0, d);
    do_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    w(5);
    // R9: reset state
    chk(!sda_oe && !sda_o, "R9", {sda_oe, sda_o}, 0);
    rst_n = 1'b1;
    w(5);

    // R1: wrong device type, no ack on this or later bytes
    do_start;
    wbyte(8'hB2, ack); chk(!ack, "R1", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R1", ack, 0);
    do_stop;

    // R2, R4: single byte then random read
    write_one(11'h123, 8'h5A, "R2");
    read_one(11'h123, d); chk(d == 8'h5A, "R2", d, 8'h5A);

    // R3, R6: page write and sequential read across the wrap
    write_pat(11'h7FE, 4);
    read_pat(11'h7FE, 4, "R3");

    // sweep a full 256-byte page
    write_pat(11'h500, 256);
    read_pat(11'h500, 256, "R6");

    // R5: buffer lower byte after a 2-byte read at 0x5A0 is 0xA2
    read_pat(11'h5A0, 2, "R4");
    do_start;
    wbyte(ctrl(11'h500, 1'b1), ack); chk(ack, "R5", ack, 1);
    rbyte(1'b0, d); chk(d == pat(11'h5A2), "R5", d, pat(11'h5A2));
    do_stop;

    // R7: protected write is acked but not stored; reads unaffected
    wp = 1'b1;
    write_one(11'h510, 8'hEE, "R7");
    read_one(11'h510, d); chk(d == pat(11'h510), "R7", d, pat(11'h510));
    wp = 1'b0;
    read_one(11'h510, d); chk(d == pat(11'h510), "R7", d, pat(11'h510));

    // R8: stop after 5 data bits leaves old value
    write_one(11'h140, 8'h33, "R2");
    do_start;
    wbyte(ctrl(11'h140, 1'b0), ack);
    wbyte(8'h40, ack);
    for (int i = 7; i >= 3; i--) bit_out(8'h77 >> i);
    do_stop;
    chk(!sda_oe, "R8", sda_oe, 0);
    read_one(11'h140, d); chk(d == 8'h33, "R8", d, 8'h33);

    // R10: start after 3 data bits, then current read of 0x140
    do_start;
    wbyte(ctrl(11'h140, 1'b0), ack);
    wbyte(8'h40, ack);
    for (int i = 7; i >= 5; i--) bit_out(1'b0);
    do_start;
    wbyte(ctrl(11'h140, 1'b1), ack); chk(ack, "R10", ack, 1);
    rbyte(1'b0, d); chk(d == 8'h33, "R10", d, 8'h33);
    do_stop;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule